// File: doc/BRIEF.md
# PWM Output Fault Gate

This block sits between a free-running PWM generator and the output pins. It forces chosen outputs to a safe inactive level whenever an external fault is present or software asks for it. The generator itself is never stopped, so when the gate lets go, the outputs show the generator's current waveform at once. The gate only blocks the path from the generator to the pins.

There are four fault inputs and two software disable bits, grouped into two banks. Fault inputs 0 and 1 plus software bit X form bank X. Fault inputs 2 and 3 plus software bit Y form bank Y. A mapping register sets which outputs each bank may force. It can be written once after reset and then stays fixed.

Each fault input goes through a two-stage synchronizer and a stability filter. Each input has its own recovery state machine with three states:
- IDLE: no fault.
- TRIP: the filtered fault is present.
- LATCH: the fault has gone but is waiting for software.

The transitions are:
- trip: IDLE or LATCH goes to TRIP when the filtered fault is high.
- auto-release: TRIP goes to IDLE when the fault drops and the pin is in automatic mode.
- hold: TRIP goes to LATCH when the fault drops and the pin is in manual mode.
- acknowledge: LATCH goes to IDLE when software writes that pin's clear bit.

The mapping register has its own two-state machine. MAP_OPEN moves to MAP_LOCKED on the first write to the mapping address.

Every trip sets a per-pin flag. Each flag drives an interrupt request through a per-pin enable.

Top module: `pwm_fault_gate`

## Requirements
- R1: After reset, `pwm_out` equals `pwm_in`, `fault_irq` is 0, and the state is as follows:
  - the mapping register holds all ones;
  - both software disable bits are 0;
  - every pin is in manual mode;
  - every interrupt enable is 0.
- R2: A register write at `wr_addr`=0 sets software disable X from `wr_data[0]` and Y from `wr_data[1]`, and takes effect after the write's clock edge.
  - An active bank X forces output o when mapping bit o (bits 3..0) is 1.
  - An active bank Y forces output o when mapping bit 4+o (bits 7..4) is 1.
  - Outputs that are not forced follow `pwm_in` in the same cycle.
- R3: Only the first write to `wr_addr`=1 after reset loads the 8-bit mapping register. All later writes to that address are ignored until the next reset.
- R4: Bank membership is fixed:
  - fault inputs 0 and 1 belong to bank X;
  - fault inputs 2 and 3 belong to bank Y.
  - A pin in TRIP or LATCH makes its bank active.
- R5: A fault input is passed through two synchronizer flops and is accepted only after its new level has held for 3 consecutive samples.
  - An input raised before clock edge E0 puts the pin in TRIP at edge E5.
  - A pulse lasting 2 cycles has no effect.
- R6: A pin in automatic mode returns to IDLE on the edge after its filtered input falls. Automatic mode is selected by `wr_addr`=2, `wr_data[i]`=1.
- R7: A pin in manual mode stays disabling after its filtered input falls. It returns to IDLE only when a clear write for it arrives while the filtered input is low. A clear written while the input is high does not release it.
- R8: Each pin's flag behaves as follows:
  - it is set when the pin enters TRIP;
  - it is cleared by writing 1 to bit i at `wr_addr`=3;
  - when a set and a clear happen in the same cycle, the set wins.
- R9: `fault_irq[i]` is pin i's flag ANDed with its interrupt enable, `wr_data[4+i]` written at `wr_addr`=2.
- R10: A forced output takes the level of its `out_pol` bit.
- R11: While the mapping register is all ones, any active bank forces all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 4 | Waveforms from the PWM generator |
| out_pol | input | 4 | Inactive level for each output |
| fault_pin | input | 4 | Asynchronous active-high fault inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 soft disable, 1 mapping, 2 mode/enable, 3 flag clear |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | Gated outputs to the pins |
| fault_irq | output | 4 | Per-pin interrupt requests |

## Verification
Two events can land on the same clock edge: a pin's flag being set by a trip, and a software clear for that same flag. The bench raises a fault input, counts five edges, and places a clear write exactly on the edge where the pin enters TRIP. It then requires the interrupt to stay asserted. A second collision is a clear written while a manual pin is still tripped. The bench judges this by the output remaining forced after the input drops, until a second clear arrives. A behavioural model tracks both cases on every clock, including under random fault and write traffic.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Recovery state of one fault input
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_TRIP  = 2'd1,
        FS_LATCH = 2'd2
    } fault_st_e;

    // Write-once mapping register state
    typedef enum logic {
        MAP_OPEN   = 1'b0,
        MAP_LOCKED = 1'b1
    } map_st_e;

    // Register addresses
    typedef enum logic [1:0] {
        RA_SWDIS = 2'd0,
        RA_MAP   = 2'd1,
        RA_MODE  = 2'd2,
        RA_CLR   = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pfd_sync_filter.sv
module pfd_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_N    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    localparam int CW = $clog2(STABLE_N + 1);

    logic [SYNC_STAGES-1:0] sy_q;
    logic [CW-1:0]          run_q;
    logic                   level_q;
    logic                   smp;

    assign smp   = sy_q[SYNC_STAGES-1];
    assign level = level_q;

    // Synchronizer chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= {sy_q[SYNC_STAGES-2:0], din};
        end
    end

    // Accept a new level only after STABLE_N consecutive differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (smp == level_q) begin
            run_q <= '0;
        end else if (run_q == CW'(STABLE_N - 1)) begin
            level_q <= smp;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/pfd_fault_fsm.sv
module pfd_fault_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic filt,
    input  logic auto_mode,
    input  logic clr_req,
    output logic pin_dis,
    output logic flag
);
    fault_st_e st_q, st_d;
    logic      set_flag;
    logic      flag_q;

    // Next state
    always_comb begin
        st_d     = st_q;
        set_flag = 1'b0;
        unique case (st_q)
            FS_IDLE: begin
                if (filt) begin
                    st_d     = FS_TRIP;
                    set_flag = 1'b1;
                end
            end
            FS_TRIP: begin
                if (!filt) begin
                    st_d = auto_mode ? FS_IDLE : FS_LATCH;
                end
            end
            FS_LATCH: begin
                if (filt) begin
                    st_d     = FS_TRIP;
                    set_flag = 1'b1;
                end else if (clr_req) begin
                    st_d = FS_IDLE;
                end
            end
            default: st_d = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Flag: set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_flag) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        pin_dis = (st_q != FS_IDLE);
        flag    = flag_q;
    end
endmodule

// File: rtl/pfd_regs.sv
module pfd_regs
    import pfd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_PIN  = 4,
    parameter int MAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        sw_dis,
    output logic [MAP_W-1:0]  map_q,
    output logic [N_PIN-1:0]  auto_q,
    output logic [N_PIN-1:0]  irq_en,
    output logic [N_PIN-1:0]  clr_pulse,
    output logic              map_locked
);
    map_st_e          mst_q, mst_d;
    logic             wr_sw, wr_map, wr_mode, wr_clr;
    logic [MAP_W-1:0] map_r;

    always_comb begin
        wr_sw   = wr_en && (wr_addr == RA_SWDIS);
        wr_map  = wr_en && (wr_addr == RA_MAP);
        wr_mode = wr_en && (wr_addr == RA_MODE);
        wr_clr  = wr_en && (wr_addr == RA_CLR);
    end

    // Mapping lock state machine
    always_comb begin
        mst_d = mst_q;
        unique case (mst_q)
            MAP_OPEN:   if (wr_map) mst_d = MAP_LOCKED;
            MAP_LOCKED: mst_d = MAP_LOCKED;
            default:    mst_d = MAP_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q <= MAP_OPEN;
        end else begin
            mst_q <= mst_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_r <= '1;
        end else if (wr_map && (mst_q == MAP_OPEN)) begin
            map_r <= wr_data[MAP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_dis <= '0;
            auto_q <= '0;
            irq_en <= '0;
        end else begin
            if (wr_sw) begin
                sw_dis <= wr_data[1:0];
            end
            if (wr_mode) begin
                auto_q <= wr_data[N_PIN-1:0];
                irq_en <= wr_data[N_PIN +: N_PIN];
            end
        end
    end

    always_comb begin
        clr_pulse  = wr_clr ? wr_data[N_PIN-1:0] : '0;
        map_q      = map_r;
        map_locked = (mst_q == MAP_LOCKED);
    end
endmodule

// File: rtl/pfd_out_gate.sv
module pfd_out_gate #(
    parameter int N_OUT = 4
) (
    input  logic               bank_x,
    input  logic               bank_y,
    input  logic [2*N_OUT-1:0] map_q,
    input  logic [N_OUT-1:0]   pwm_in,
    input  logic [N_OUT-1:0]   out_pol,
    output logic [N_OUT-1:0]   pwm_out
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic kill;
        assign kill       = (map_q[o] & bank_x) | (map_q[N_OUT+o] & bank_y);
        assign pwm_out[o] = kill ? out_pol[o] : pwm_in[o];
    end
endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate #(
    parameter int N_OUT         = 4,
    parameter int PINS_PER_BANK = 2,
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_N      = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_OUT-1:0]       pwm_in,
    input  logic [N_OUT-1:0]       out_pol,
    input  logic [2*PINS_PER_BANK-1:0] fault_pin,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [N_OUT-1:0]       pwm_out,
    output logic [2*PINS_PER_BANK-1:0] fault_irq
);
    localparam int N_PIN = 2 * PINS_PER_BANK;
    localparam int MAP_W = 2 * N_OUT;

    logic [1:0]       sw_dis;
    logic [MAP_W-1:0] map_q;
    logic [N_PIN-1:0] auto_q, irq_en, clr_pulse;
    logic [N_PIN-1:0] filt_lvl, pin_dis, flag;
    logic             map_locked;
    logic             bank_x, bank_y;

    pfd_regs #(
        .DATA_W (DATA_W),
        .N_PIN  (N_PIN),
        .MAP_W  (MAP_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sw_dis     (sw_dis),
        .map_q      (map_q),
        .auto_q     (auto_q),
        .irq_en     (irq_en),
        .clr_pulse  (clr_pulse),
        .map_locked (map_locked)
    );

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        pfd_sync_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .STABLE_N    (STABLE_N)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (fault_pin[i]),
            .level (filt_lvl[i])
        );

        pfd_fault_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .filt      (filt_lvl[i]),
            .auto_mode (auto_q[i]),
            .clr_req   (clr_pulse[i]),
            .pin_dis   (pin_dis[i]),
            .flag      (flag[i])
        );
    end

    assign bank_x    = (|pin_dis[PINS_PER_BANK-1:0]) | sw_dis[0];
    assign bank_y    = (|pin_dis[N_PIN-1:PINS_PER_BANK]) | sw_dis[1];
    assign fault_irq = flag & irq_en;

    pfd_out_gate #(
        .N_OUT (N_OUT)
    ) u_gate (
        .bank_x  (bank_x),
        .bank_y  (bank_y),
        .map_q   (map_q),
        .pwm_in  (pwm_in),
        .out_pol (out_pol),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int N_OUT = 4,
    parameter int N_PIN = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_OUT-1:0]   pwm_out,
    input logic [N_OUT-1:0]   out_pol,
    input logic [2*N_OUT-1:0] map_q,
    input logic               map_locked,
    input logic [1:0]         sw_dis,
    input logic [N_PIN-1:0]   filt_lvl,
    input logic [N_PIN-1:0]   pin_dis,
    input logic [N_PIN-1:0]   flag,
    input logic [N_PIN-1:0]   auto_q,
    input logic [N_PIN-1:0]   clr_pulse
);
    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        map_locked |=> $stable(map_q));  // R3
    AST_MAP_OPEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !map_locked |-> (map_q == '1));  // R3

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin_chk
        AST_FLAG_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(filt_lvl[i]) |=> flag[i]);  // R8
        AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(filt_lvl[i]) && auto_q[i] |=> !pin_dis[i]);  // R6
        AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            pin_dis[i] && !auto_q[i] && !clr_pulse[i] |=> pin_dis[i]);  // R7
        AST_TRIP_NEEDS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_dis[i]) |-> filt_lvl[i]);  // R5
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        AST_SW_X_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
            sw_dis[0] && map_q[o] |-> pwm_out[o] == out_pol[o]);  // R2
        AST_SW_Y_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
            sw_dis[1] && map_q[N_OUT+o] |-> pwm_out[o] == out_pol[o]);  // R2
    end
endmodule

bind pwm_fault_gate pfd_checker #(
    .N_OUT (N_OUT),
    .N_PIN (N_PIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .out_pol    (out_pol),
    .map_q      (map_q),
    .map_locked (map_locked),
    .sw_dis     (sw_dis),
    .filt_lvl   (filt_lvl),
    .pin_dis    (pin_dis),
    .flag       (flag),
    .auto_q     (auto_q),
    .clr_pulse  (clr_pulse)
);

// File: tb/pwm_fault_gate_bench.sv
`timescale 1ns/1ps
module pwm_fault_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pwm_in = 4'b0101;
    logic [3:0] out_pol = 4'b1010;
    logic [3:0] fault_pin = 4'b0000;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] pwm_out, fault_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_fault_gate u_pwm_fault_gate (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .out_pol(out_pol),
        .fault_pin(fault_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .fault_irq(fault_irq)
    );

    // Behavioural reference model
    logic [3:0] m_s1, m_s2, m_flt, m_flag, m_auto, m_ien, m_clr;
    logic [1:0] m_sw;
    logic [7:0] m_map;
    bit         m_lock, m_setf;
    int         m_cnt [4];
    int         m_st  [4];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_flt = '0; m_flag = '0;
            m_auto = '0; m_ien = '0; m_sw = '0; m_map = 8'hFF; m_lock = 1'b0;
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0;
                m_st[i]  = 0;
            end
        end else begin
            m_clr = (wr_en && wr_addr == 2'd3) ? wr_data[3:0] : 4'd0;
            for (int i = 0; i < 4; i++) begin
                m_setf = 1'b0;
                case (m_st[i])
                    0: if (m_flt[i]) begin m_st[i] = 1; m_setf = 1'b1; end
                    1: if (!m_flt[i]) m_st[i] = m_auto[i] ? 0 : 2;
                    default: if (m_flt[i]) begin m_st[i] = 1; m_setf = 1'b1; end
                             else if (m_clr[i]) m_st[i] = 0;
                endcase
                if (m_setf) m_flag[i] = 1'b1;
                else if (m_clr[i]) m_flag[i] = 1'b0;
                if (m_s2[i] == m_flt[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == 2) begin m_flt[i] = m_s2[i]; m_cnt[i] = 0; end
                else m_cnt[i]++;
                m_s2[i] = m_s1[i];
                m_s1[i] = fault_pin[i];
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_sw = wr_data[1:0];
                    2'd1: if (!m_lock) begin m_map = wr_data; m_lock = 1'b1; end
                    2'd2: begin m_auto = wr_data[3:0]; m_ien = wr_data[7:4]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [3:0] model_out();
        logic bx, by;
        logic [3:0] r;
        bx = (m_st[0] != 0) || (m_st[1] != 0) || m_sw[0];
        by = (m_st[2] != 0) || (m_st[3] != 0) || m_sw[1];
        for (int o = 0; o < 4; o++) begin
            r[o] = ((m_map[o] && bx) || (m_map[4+o] && by)) ? out_pol[o] : pwm_in[o];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk("R2 R10 model pwm_out", {4'd0, pwm_out}, {4'd0, model_out()});
            chk("R9 model fault_irq", {4'd0, fault_irq}, {4'd0, m_flag & m_ien});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 pass-through after reset", {4'd0, pwm_out}, 8'h05);
        chk("R1 irq low after reset", {4'd0, fault_irq}, 8'h00);

        wr(2'd0, 8'h01); #1;
        chk("R11 all-ones map bank X forces all", {4'd0, pwm_out}, 8'h0A);
        @(negedge clk) out_pol = 4'b0011;
        #1 chk("R10 forced level follows out_pol", {4'd0, pwm_out}, 8'h03);
        @(negedge clk) out_pol = 4'b1010;
        wr(2'd0, 8'h02); #1;
        chk("R11 all-ones map bank Y forces all", {4'd0, pwm_out}, 8'h0A);

        wr(2'd0, 8'h00);
        wr(2'd1, 8'h21);
        wr(2'd0, 8'h01); #1;
        chk("R2 bank X map bit0 forces out0", {4'd0, pwm_out}, 8'h04);
        wr(2'd0, 8'h02); #1;
        chk("R2 bank Y map bit5 forces out1", {4'd0, pwm_out}, 8'h07);
        wr(2'd1, 8'hFF); #1;
        chk("R3 second map write ignored", {4'd0, pwm_out}, 8'h07);
        wr(2'd0, 8'h00); #1;
        chk("R2 soft disable removed", {4'd0, pwm_out}, 8'h05);

        // Filter: 2-cycle pulse rejected
        wr(2'd2, 8'hFF);
        @(negedge clk) fault_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk) fault_pin[0] = 1'b0;
        repeat (8) @(negedge clk);
        #1 chk("R5 short pulse rejected out", {4'd0, pwm_out}, 8'h05);
        chk("R5 short pulse no irq", {4'd0, fault_irq}, 8'h00);

        // Filter latency and bank X membership
        @(negedge clk) fault_pin[0] = 1'b1;
        repeat (5) @(posedge clk);
        #1 chk("R5 not yet tripped after E4", {4'd0, pwm_out}, 8'h05);
        @(posedge clk);
        #1 chk("R4 pin0 trips bank X at E5", {4'd0, pwm_out}, 8'h04);
        chk("R8 flag set on trip", {4'd0, fault_irq}, 8'h01);
        @(negedge clk) fault_pin[0] = 1'b0;
        repeat (6) @(posedge clk);
        #1 chk("R6 auto release", {4'd0, pwm_out}, 8'h05);
        chk("R8 flag persists after release", {4'd0, fault_irq}, 8'h01);
        wr(2'd3, 8'h01); #1;
        chk("R8 flag cleared by write", {4'd0, fault_irq}, 8'h00);

        // Manual recovery on pin2 (bank Y)
        wr(2'd2, 8'hFB);
        @(negedge clk) fault_pin[2] = 1'b1;
        repeat (8) @(negedge clk);
        #1 chk("R4 pin2 trips bank Y", {4'd0, pwm_out}, 8'h07);
        chk("R8 pin2 flag", {4'd0, fault_irq}, 8'h04);
        wr(2'd3, 8'h04); #1;
        chk("R8 clear while high drops flag", {4'd0, fault_irq}, 8'h00);
        @(negedge clk) fault_pin[2] = 1'b0;
        repeat (8) @(negedge clk);
        #1 chk("R7 manual hold after early clear", {4'd0, pwm_out}, 8'h07);
        wr(2'd3, 8'h04); #1;
        chk("R7 clear while low releases", {4'd0, pwm_out}, 8'h05);

        // Set and clear on the same edge
        @(negedge clk) fault_pin[3] = 1'b1;
        repeat (5) @(posedge clk);
        wr(2'd3, 8'h08); #1;
        chk("R8 set wins over same-cycle clear", {4'd0, fault_irq}, 8'h08);
        wr(2'd2, 8'h7B); #1;
        chk("R9 enable off masks irq", {4'd0, fault_irq}, 8'h00);
        wr(2'd2, 8'hFB); #1;
        chk("R9 enable on shows irq", {4'd0, fault_irq}, 8'h08);
        @(negedge clk) fault_pin[3] = 1'b0;
        repeat (8) @(negedge clk);
        #1 chk("R6 pin3 auto release", {4'd0, pwm_out}, 8'h05);
        wr(2'd3, 8'h0F);

        // Random traffic judged by the model
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            pwm_in = 4'($urandom);
            if ($urandom % 8 == 0) out_pol = 4'($urandom);
            for (int i = 0; i < 4; i++) begin
                if ($urandom % 5 == 0) fault_pin[i] = ~fault_pin[i];
            end
            wr_en   = ($urandom % 12 == 0);
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
        end
        @(negedge clk) wr_en = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule